// File: doc/BRIEF.md
# GPIO Expander Register Front End

This block is the register side of a 16-bit I2C GPIO expander. An I2C slave byte engine in front of it handles the bit-level protocol. The engine reports start and stop conditions, a matched address byte together with its read/write bit, and each data byte it receives. It also asks for the next byte to send during a read. For each received byte the block answers with an acknowledge decision, and for each read request it returns one byte.

In a write transaction, the first byte after the address is a command byte. Its low four bits choose one of sixteen byte-wide registers, and its top bit turns on automatic pointer stepping. Its middle three bits must be zero. Any other value is a reserved code: the block refuses it and leaves the pointer where it was. The sixteen registers are laid out as pairs, with port 0 at the even offset and port 1 at the odd one: sampled inputs, polarity inversion, bus-hold enable, pull selector, direction, output value, interrupt mask and interrupt status. The input and interrupt status pairs are read-only. The pin side feeds in raw pin levels, which pass through a synchronizer, and the interrupt status flags. The pin side receives the contents of the writable registers.

Top module: `gpx_reg_front`

## Requirements
- R1: After reset the pointer is 00h and auto-increment is off, and every writable register (so every pin-side control output) is zero; a read issued before any command byte returns offset 00h.
- R2: The first byte received after a write address (read/write bit 0) is taken as a command byte when its bits 6 to 4 are zero. It is acknowledged, bits 3 to 0 become the pointer, and bit 7 becomes the auto-increment flag.
- R3: A command byte with any of bits 6 to 4 set is not acknowledged. The pointer and flag keep their old values, and every later data byte of that transaction is not acknowledged and changes no register.
- R4: Each data byte after an accepted command byte is acknowledged and written to the register at the pointer; the other registers keep their values.
- R5: With auto-increment set, the pointer steps by one after every data byte written and after every byte read, and wraps from 0Fh to 00h.
- R6: With auto-increment clear, the pointer does not move, so repeated data bytes all land in the same register and repeated reads return the same register.
- R7: Offsets 00h, 01h, 0Eh and 0Fh are read-only: data bytes sent to them are acknowledged and discarded.
- R8: A read returns the register at the current pointer. The pointer survives a repeated start, so a command byte followed by a read address reads the selected register.
- R9: Offsets 00h/01h read as the pin levels of port 0 (bits 7:0) and port 1 (bits 15:8) after SYNC_STAGES clock cycles of synchronization, each bit exclusive-ORed with the matching polarity bit (offsets 02h/03h).
- R10: Offsets 0Eh/0Fh read the interrupt status flags input, bits 7:0 and 15:8 respectively.
- R11: Each writable pair drives a 16-bit output, with the even offset on bits 7:0 and the odd offset on bits 15:8: 02h/03h polarity, 04h/05h bus-hold enable, 06h/07h pull selector, 08h/09h direction, 0Ah/0Bh output value, 0Ch/0Dh interrupt mask.
- R12: ack_valid pulses exactly one cycle after every rx_valid, and tx_valid pulses exactly one cycle after every tx_req. A byte received outside a write transaction (idle, after a stop, or in a read) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start or repeated start seen (pulse) |
| bus_stop | input | 1 | Stop seen (pulse) |
| addr_valid | input | 1 | Own address byte received (pulse) |
| addr_rw | input | 1 | Read/write bit of the address, 1 = read |
| rx_valid | input | 1 | Received data byte present (pulse) |
| rx_data | input | DW | Received data byte |
| ack_valid | output | 1 | Acknowledge decision present |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| tx_req | input | 1 | Engine needs the next read byte (pulse) |
| tx_valid | output | 1 | Read byte present |
| tx_data | output | DW | Read byte |
| pin_in | input | 2*DW | Raw pin levels |
| int_flags | input | 2*DW | Interrupt status flags from the pin side |
| pol_o | output | 2*DW | Polarity inversion bits |
| hold_en_o | output | 2*DW | Bus-hold enables |
| pull_sel_o | output | 2*DW | Pull selector bits |
| dir_o | output | 2*DW | Direction bits |
| out_o | output | 2*DW | Output values |
| irq_mask_o | output | 2*DW | Interrupt mask bits |

## Verification
The bench builds the block with its defaults: byte width 8 and two synchronizer stages. At byte width 8, the command byte has exactly three reserved bits between the pointer and the flag, and the 17-byte auto-incrementing burst wraps the pointer through both read-only pairs and back onto a writable register. With two sync stages, a pin change is observed through a later read after a short, known delay, and polarity is applied on top of it.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int MAP_W = 4;
    localparam int NREG  = 1 << MAP_W;

    // offsets of port 0 of each register pair; port 1 sits one above
    localparam logic [MAP_W-1:0] OFS_IN   = 4'h0;
    localparam logic [MAP_W-1:0] OFS_POL  = 4'h2;
    localparam logic [MAP_W-1:0] OFS_HOLD = 4'h4;
    localparam logic [MAP_W-1:0] OFS_PULL = 4'h6;
    localparam logic [MAP_W-1:0] OFS_DIR  = 4'h8;
    localparam logic [MAP_W-1:0] OFS_OUT  = 4'hA;
    localparam logic [MAP_W-1:0] OFS_MASK = 4'hC;
    localparam logic [MAP_W-1:0] OFS_INTS = 4'hE;

    // one bit per offset, set where the register cannot be written
    localparam logic [NREG-1:0] RO_MASK = 16'hC003;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CMD,
        PH_WDATA,
        PH_READ
    } phase_e;

endpackage

// File: rtl/gpx_in_sync.sv
module gpx_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_raw;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpx_cmd_ctrl.sv
module gpx_cmd_ctrl
    import gpx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             addr_valid,
    input  logic             addr_rw,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             tx_req,
    output logic             wr_en,
    output logic [MAP_W-1:0] wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic [MAP_W-1:0] rd_addr,
    output logic             ack_valid,
    output logic             ack
);

    localparam int FLAG_BIT = DW - 1;
    localparam int RSV_HI   = DW - 2;
    localparam int RSV_LO   = MAP_W;

    typedef struct packed {
        phase_e           phase;
        logic [MAP_W-1:0] ptr;
        logic             ai;
        logic             ack_v;
        logic             ack;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  cmd_ok;
    logic  ev_frame;

    assign cmd_ok   = (rx_data[RSV_HI:RSV_LO] == '0);
    assign ev_frame = bus_start || bus_stop || addr_valid;

    always_comb begin
        st_d       = st_q;
        st_d.ack_v = rx_valid;
        st_d.ack   = 1'b0;
        wr_en      = 1'b0;
        wr_addr    = st_q.ptr;
        wr_data    = rx_data;

        if (bus_start || bus_stop) begin
            st_d.phase = PH_IDLE;
        end else if (addr_valid) begin
            st_d.phase = addr_rw ? PH_READ : PH_CMD;
        end else if (rx_valid) begin
            case (st_q.phase)
                PH_CMD: begin
                    if (cmd_ok) begin
                        st_d.ptr   = rx_data[MAP_W-1:0];
                        st_d.ai    = rx_data[FLAG_BIT];
                        st_d.ack   = 1'b1;
                        st_d.phase = PH_WDATA;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
                PH_WDATA: begin
                    st_d.ack = 1'b1;
                    wr_en    = 1'b1;
                    if (st_q.ai) st_d.ptr = st_q.ptr + MAP_W'(1);
                end
                default: ;
            endcase
        end else if (tx_req && st_q.phase == PH_READ && st_q.ai) begin
            st_d.ptr = st_q.ptr + MAP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, ptr: '0, ai: 1'b0, ack_v: 1'b0, ack: 1'b0};
        else        st_q <= st_d;
    end

    assign rd_addr   = st_q.ptr;
    assign ack_valid = st_q.ack_v;
    assign ack       = st_q.ack;

    // R12
    ack_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> ack_valid);

    // R3
    bad_cmd_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ev_frame && st_q.phase == PH_CMD && rx_data[RSV_HI:RSV_LO] != '0)
        |=> (!ack && st_q.ptr == $past(st_q.ptr) && st_q.ai == $past(st_q.ai)));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ev_frame && st_q.phase == PH_WDATA && st_q.ai)
        |=> (st_q.ptr == $past(st_q.ptr) + MAP_W'(1)));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_valid || tx_req) && !ev_frame && st_q.phase != PH_CMD && !st_q.ai)
        |=> $stable(st_q.ptr));

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [MAP_W-1:0]          wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [MAP_W-1:0]          rd_addr,
    input  logic [2*DW-1:0]           in_val,
    input  logic [2*DW-1:0]           ints_val,
    output logic [DW-1:0]             rd_data,
    output logic [NREG-1:0][DW-1:0]   regs_o
);

    logic [NREG-1:0][DW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && !RO_MASK[wr_addr]) regs_d[wr_addr] = wr_data;
        for (int i = 0; i < NREG; i++) begin
            if (RO_MASK[i]) regs_d[i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (rd_addr)
            OFS_IN:                  rd_data = in_val[DW-1:0];
            OFS_IN + MAP_W'(1):      rd_data = in_val[2*DW-1:DW];
            OFS_INTS:                rd_data = ints_val[DW-1:0];
            OFS_INTS + MAP_W'(1):    rd_data = ints_val[2*DW-1:DW];
            default:                 rd_data = regs_q[rd_addr];
        endcase
    end

    assign regs_o = regs_q;

    // R4
    rw_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !RO_MASK[wr_addr]) |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

    // R7
    ro_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && RO_MASK[wr_addr]) |=> $stable(regs_q));

endmodule

// File: rtl/gpx_reg_front.sv
module gpx_reg_front
    import gpx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_start,
    input  logic            bus_stop,
    input  logic            addr_valid,
    input  logic            addr_rw,
    input  logic            rx_valid,
    input  logic [DW-1:0]   rx_data,
    output logic            ack_valid,
    output logic            ack,
    input  logic            tx_req,
    output logic            tx_valid,
    output logic [DW-1:0]   tx_data,
    input  logic [2*DW-1:0] pin_in,
    input  logic [2*DW-1:0] int_flags,
    output logic [2*DW-1:0] pol_o,
    output logic [2*DW-1:0] hold_en_o,
    output logic [2*DW-1:0] pull_sel_o,
    output logic [2*DW-1:0] dir_o,
    output logic [2*DW-1:0] out_o,
    output logic [2*DW-1:0] irq_mask_o
);

    localparam int PORTS = 2;
    localparam int PIN_W = PORTS * DW;

    typedef struct packed {
        logic          tx_v;
        logic [DW-1:0] tx_b;
    } txo_t;

    logic                    wr_en;
    logic [MAP_W-1:0]        wr_addr;
    logic [DW-1:0]           wr_data;
    logic [MAP_W-1:0]        rd_addr;
    logic [DW-1:0]           rd_data;
    logic [NREG-1:0][DW-1:0] regs;
    logic [PIN_W-1:0]        pin_sync;
    logic [PIN_W-1:0]        in_val;
    txo_t                    tx_d, tx_q;

    gpx_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_sync (pin_sync)
    );

    gpx_cmd_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .addr_valid (addr_valid),
        .addr_rw    (addr_rw),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .tx_req     (tx_req),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .ack_valid  (ack_valid),
        .ack        (ack)
    );

    gpx_regfile #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .in_val   (in_val),
        .ints_val (int_flags),
        .rd_data  (rd_data),
        .regs_o   (regs)
    );

    assign in_val = pin_sync ^ pol_o;

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            assign pol_o     [p*DW +: DW] = regs[OFS_POL  + MAP_W'(p)];
            assign hold_en_o [p*DW +: DW] = regs[OFS_HOLD + MAP_W'(p)];
            assign pull_sel_o[p*DW +: DW] = regs[OFS_PULL + MAP_W'(p)];
            assign dir_o     [p*DW +: DW] = regs[OFS_DIR  + MAP_W'(p)];
            assign out_o     [p*DW +: DW] = regs[OFS_OUT  + MAP_W'(p)];
            assign irq_mask_o[p*DW +: DW] = regs[OFS_MASK + MAP_W'(p)];
        end
    endgenerate

    always_comb begin
        tx_d      = tx_q;
        tx_d.tx_v = tx_req;
        if (tx_req) tx_d.tx_b = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign tx_valid = tx_q.tx_v;
    assign tx_data  = tx_q.tx_b;

    // R12
    tx_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);

    // R12
    tx_only_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !tx_valid);

endmodule

// File: tb/tb_gpx_reg_front.sv
module tb_gpx_reg_front;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_start = 0, bus_stop = 0, addr_valid = 0, addr_rw = 0;
    logic          rx_valid = 0, tx_req = 0;
    logic [DW-1:0] rx_data = '0;
    logic          ack_valid, ack, tx_valid;
    logic [DW-1:0] tx_data;
    logic [15:0]   pin_in = 16'hA55A;
    logic [15:0]   int_flags = 16'h3C96;
    logic [15:0]   pol_o, hold_en_o, pull_sel_o, dir_o, out_o, irq_mask_o;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    gpx_reg_front dut (
        .clk(clk), .rst_n(rst_n),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_valid(addr_valid), .addr_rw(addr_rw),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .ack_valid(ack_valid), .ack(ack),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .pin_in(pin_in), .int_flags(int_flags),
        .pol_o(pol_o), .hold_en_o(hold_en_o), .pull_sel_o(pull_sel_o),
        .dir_o(dir_o), .out_o(out_o), .irq_mask_o(irq_mask_o)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // scoreboard monitor: kind 0 = ack decision, kind 1 = read byte
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (ack_valid || tx_valid)) begin
                int    got;
                int    want;
                string tg;
                got = ack_valid ? {23'd0, ack} : (256 + int'(tx_data));
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL unexpected result R12 actual=%0h expected=none", got);
                end else begin
                    want = exp_q.pop_front();
                    tg   = tag_q.pop_front();
                    if (got != want) begin
                        fails++;
                        $display("FAIL %s actual=%0h expected=%0h", tg, got, want);
                    end
                end
            end
        end
    end

    task automatic pulse_start();
        bus_start = 1; @(negedge clk); bus_start = 0;
    endtask

    task automatic pulse_stop();
        bus_stop = 1; @(negedge clk); bus_stop = 0;
    endtask

    task automatic send_addr(input logic rw);
        addr_valid = 1; addr_rw = rw; @(negedge clk); addr_valid = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tg);
        exp_q.push_back({31'd0, exp_ack});
        tag_q.push_back(tg);
        rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
    endtask

    task automatic read_byte(input logic [7:0] exp_b, input string tg);
        exp_q.push_back(256 + int'(exp_b));
        tag_q.push_back(tg);
        tx_req = 1; @(negedge clk); tx_req = 0;
    endtask

    task automatic chk16(input logic [15:0] act, input logic [15:0] exp_v, input string tg);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp_v);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] pol0, pol1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset values on every control output
        chk16(pol_o | hold_en_o | pull_sel_o | dir_o | out_o | irq_mask_o, 16'h0000, "R1 reset outputs");

        // R1/R9: read before any command hits offset 00h, no stepping
        repeat (3) @(negedge clk);
        pulse_start(); send_addr(1);
        read_byte(8'h5A, "R1 read reg00 after reset");
        read_byte(8'h5A, "R1 pointer holds after reset");
        pulse_stop();

        // R2/R4/R5/R7: auto-increment burst from 02h, through RO regs, wrapping
        pulse_start(); send_addr(0);
        send_byte(8'h82, 1'b1, "R2 command accept");
        for (int k = 0; k < 12; k++) send_byte(8'(8'h11 * (k + 1)), 1'b1, "R4 data ack");
        send_byte(8'hE1, 1'b1, "R7 ack on 0Eh");
        send_byte(8'hE2, 1'b1, "R7 ack on 0Fh");
        send_byte(8'hE3, 1'b1, "R7 ack on 00h after wrap");
        send_byte(8'hE4, 1'b1, "R7 ack on 01h");
        send_byte(8'hDD, 1'b1, "R5 wrap write to 02h");
        pulse_stop();
        pol0 = 8'hDD; pol1 = 8'h22;
        chk16(pol_o,      {pol1, pol0},   "R5 polarity after wrap");
        chk16(hold_en_o,  16'h4433,       "R11 bus-hold pair");
        chk16(pull_sel_o, 16'h6655,       "R11 pull pair");
        chk16(dir_o,      16'h8877,       "R11 direction pair");
        chk16(out_o,      16'hAA99,       "R11 output pair");
        chk16(irq_mask_o, 16'hCCBB,       "R11 mask pair");

        // R3: reserved code refused, pointer (03h) and flag (1) kept
        pulse_start(); send_addr(0);
        send_byte(8'h15, 1'b0, "R3 reserved code nack");
        send_byte(8'h5E, 1'b0, "R3 data after reserved nack");
        pulse_start(); send_addr(1);
        read_byte(8'h22, "R3 pointer kept at 03h");
        read_byte(8'h33, "R8 read steps with flag to 04h");
        pulse_stop();
        chk16(pol_o, {pol1, pol0}, "R3 no register written");

        // R6: no stepping, repeated bytes to 0Ah, repeated reads
        pulse_start(); send_addr(0);
        send_byte(8'h0A, 1'b1, "R2 command 0Ah");
        send_byte(8'h01, 1'b1, "R6 data 1");
        send_byte(8'h02, 1'b1, "R6 data 2");
        send_byte(8'h03, 1'b1, "R6 data 3");
        chk16(out_o, 16'hAA03, "R6 last byte only, neighbour kept");
        pulse_start(); send_addr(1);
        read_byte(8'h03, "R8 read after repeated start");
        read_byte(8'h03, "R6 read pointer fixed");
        pulse_stop();

        // R7/R10: write to status discarded, status reads flags
        pulse_start(); send_addr(0);
        send_byte(8'h0E, 1'b1, "R2 command 0Eh");
        send_byte(8'hFF, 1'b1, "R7 ack on status write");
        pulse_start(); send_addr(1);
        read_byte(8'h96, "R10 status port 0");
        read_byte(8'h96, "R7 status unchanged");
        pulse_start(); send_addr(0);
        send_byte(8'h8F, 1'b1, "R2 command 0Fh with flag");
        pulse_start(); send_addr(1);
        read_byte(8'h3C, "R10 status port 1");
        read_byte(8'h5A ^ pol0, "R5 read wrap to 00h");
        pulse_stop();

        // R9: new pin levels after synchronizer, polarity applied
        pin_in = 16'h0F0F;
        repeat (4) @(negedge clk);
        pulse_start(); send_addr(0);
        send_byte(8'h80, 1'b1, "R2 command 00h with flag");
        pulse_start(); send_addr(1);
        read_byte(8'h0F ^ pol0, "R9 input port 0");
        read_byte(8'h0F ^ pol1, "R9 input port 1");
        send_byte(8'h34, 1'b0, "R12 byte in read refused");
        pulse_stop();

        // R12: byte while idle refused
        send_byte(8'h12, 1'b0, "R12 idle byte refused");
        chk16(out_o, 16'hAA03, "R12 idle byte no write");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R12 missing results actual=%0d expected=0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule